// File: doc/BRIEF.md
# Auto-Reload Timer with Interrupt Flags

This block is a byte-wide up-counter for a small microcontroller. A fixed-ratio prescaler divides the system clock, and the counter advances by one on each prescaler terminal count while the run bit is set. When the counter would step past its all-ones value, it takes its next value from a reload register instead of wrapping to zero. Software sets the period by choosing the reload value.

The core reaches four byte registers over a simple bus: a write strobe, an address, write data and combinational read data. They are a mode register, a status register, a reload register and a compare register. Two events set sticky flags in the status register. One is the overflow, taken when the counter reloads. The other is the compare match, taken when the counter steps to the compare value. Each flag has its own enable bit in the mode register. One interrupt line is high while any flag and its enable are both set. Software clears a flag by writing zero to its bit.

Top module: `rtt_timer_top`

## Requirements
- R1: After reset the mode and status registers read 00h and the interrupt line is low. The counter does not advance until the run bit is written with 1.
- R2: Writing the mode register with bit 7 = 1 copies the reload register into the counter and restarts the prescaler from zero. Bit 7 always reads 0. A counter step that falls in the same cycle as this load is dropped.
- R3: Mode bit 6 is the run bit. While it is 0, the prescaler and the counter both hold their values. Setting it again resumes the count from the held prescaler phase.
- R4: While running, the counter advances once every PSC_DIV clocks. With the prescaler cleared at edge E0, the k-th step takes effect at edge E0 + k*PSC_DIV.
- R5: Status bit 1, the compare flag, is set at the edge where a counter step makes the counter equal to the compare register.
- R6: A step taken from FFh loads the counter from the reload register instead of 00h. Status bit 0, the overflow flag, is set at that same edge.
- R7: Writing the status register clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1.
- R8: If a flag's event and a clear of that flag fall in the same cycle, the flag ends up set.
- R9: The interrupt line is high exactly when (status bit 1 AND mode bit 3) OR (status bit 0 AND mode bit 2).
- R10: Mode bits 7, 5, 4, 1 and 0 and status bits 7 to 2 read as 0. The reload and compare registers read back the last value written.
- R11: The registers decode at these addresses: mode E5h, status E6h, reload E7h, compare E8h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with PSC_DIV = 4. This makes every counter step land a known four edges after the previous one, so the compare and overflow flags can be checked at the exact edge they should set. A reload value near FFh brings the overflow and the reload into a few dozen cycles. Counting edges from a load then tells a reload apart from a wrap to zero. It also lets the bench place a clear write on the very edge of an overflow.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int NFLAG = 2;

  // mode register bit positions
  localparam int MODE_LOAD = 7;
  localparam int MODE_RUN  = 6;
  localparam int MODE_CIE  = 3;
  localparam int MODE_OIE  = 2;

  // status register bit positions (also flag vector index)
  localparam int FLAG_CMP = 1;
  localparam int FLAG_OVF = 0;

  typedef logic [DW-1:0] byte_t;

  function automatic logic at_top(input byte_t cur);
    return cur == {DW{1'b1}};
  endfunction

  function automatic byte_t step_count(input byte_t cur, input byte_t rel);
    return at_top(cur) ? rel : cur + DW'(1);
  endfunction

  function automatic byte_t pack_mode(input logic run, input logic cie, input logic oie);
    byte_t v;
    v = '0;
    v[MODE_RUN] = run;
    v[MODE_CIE] = cie;
    v[MODE_OIE] = oie;
    return v;
  endfunction

  function automatic byte_t pack_status(input logic [NFLAG-1:0] f);
    byte_t v;
    v = '0;
    v[NFLAG-1:0] = f;
    return v;
  endfunction
endpackage

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] psc_q;

  assign tick = run && (psc_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psc_q <= '0;
    else if (clear)  psc_q <= '0;
    else if (run)    psc_q <= tick ? '0 : psc_q + PW'(1);
  end

  // R4
  psc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (psc_q == '0));

  // R3
  psc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(psc_q));
endmodule

// File: rtl/rtt_counter.sv
module rtt_counter import rtt_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  load,
  input  byte_t reload,
  input  byte_t compare,
  output logic  ovf_evt,
  output logic  cmp_evt
);
  byte_t cnt_q;
  byte_t cnt_nxt;
  logic  step;

  assign step    = tick && !load;
  assign cnt_nxt = step_count(cnt_q, reload);
  assign ovf_evt = step && at_top(cnt_q);
  assign cmp_evt = step && (cnt_nxt == compare);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= reload;
    else if (step)  cnt_q <= cnt_nxt;
  end

  // R2
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(reload)));

  // R6
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_q == $past(reload)));

  // R5
  cnt_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> (cnt_q == $past(compare)));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/rtt_flags.sv
module rtt_flags import rtt_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt,
  input  logic             wr,
  input  logic [NFLAG-1:0] wbits,
  output logic [NFLAG-1:0] flag
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flag[i] <= 1'b0;
      else if (evt[i])            flag[i] <= 1'b1;
      else if (wr && !wbits[i])   flag[i] <= 1'b0;
    end

    // R8
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag[i]);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wbits[i] && !evt[i]) |=> !flag[i]);

    // R7
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt[i] && !(wr && !wbits[i])) |=> $stable(flag[i]));
  end
endmodule

// File: rtl/rtt_timer_top.sv
module rtt_timer_top import rtt_pkg::*; #(
  parameter int          PSC_DIV     = 4,
  parameter logic [7:0]  ADDR_MODE   = 8'hE5,
  parameter logic [7:0]  ADDR_STATUS = 8'hE6,
  parameter logic [7:0]  ADDR_RELOAD = 8'hE7,
  parameter logic [7:0]  ADDR_CMP    = 8'hE8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_o
);
  logic run_q, cie_q, oie_q;
  byte_t reload_q, cmp_q;
  logic wr_mode, wr_status, wr_reload, wr_cmp;
  logic load_cmd, tick, ovf_evt, cmp_evt;
  logic [NFLAG-1:0] evt, flag;

  assign wr_mode   = bus_wr && (bus_addr == ADDR_MODE);
  assign wr_status = bus_wr && (bus_addr == ADDR_STATUS);
  assign wr_reload = bus_wr && (bus_addr == ADDR_RELOAD);
  assign wr_cmp    = bus_wr && (bus_addr == ADDR_CMP);
  assign load_cmd  = wr_mode && bus_wdata[MODE_LOAD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cie_q <= 1'b0;
      oie_q <= 1'b0;
    end else if (wr_mode) begin
      run_q <= bus_wdata[MODE_RUN];
      cie_q <= bus_wdata[MODE_CIE];
      oie_q <= bus_wdata[MODE_OIE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cmp_q    <= '0;
    end else begin
      if (wr_reload) reload_q <= bus_wdata;
      if (wr_cmp)    cmp_q    <= bus_wdata;
    end
  end

  rtt_prescaler #(.DIV(PSC_DIV)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .clear (load_cmd),
    .tick  (tick)
  );

  rtt_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .load    (load_cmd),
    .reload  (reload_q),
    .compare (cmp_q),
    .ovf_evt (ovf_evt),
    .cmp_evt (cmp_evt)
  );

  always_comb begin
    evt = '0;
    evt[FLAG_CMP] = cmp_evt;
    evt[FLAG_OVF] = ovf_evt;
  end

  rtt_flags u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .wr    (wr_status),
    .wbits (bus_wdata[NFLAG-1:0]),
    .flag  (flag)
  );

  assign irq_o = (flag[FLAG_CMP] && cie_q) || (flag[FLAG_OVF] && oie_q);

  always_comb begin
    if (bus_addr == ADDR_MODE)        bus_rdata = pack_mode(run_q, cie_q, oie_q);
    else if (bus_addr == ADDR_STATUS) bus_rdata = pack_status(flag);
    else if (bus_addr == ADDR_RELOAD) bus_rdata = reload_q;
    else if (bus_addr == ADDR_CMP)    bus_rdata = cmp_q;
    else                              bus_rdata = '0;
  end

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cie_q && !oie_q) |-> !irq_o);

  // R3
  no_tick_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !tick);

  // R6
  ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag[FLAG_OVF]);
endmodule

// File: tb/rtt_timer_top_tb_top.sv
module rtt_timer_top_tb_top;
  localparam logic [7:0] A_MODE = 8'hE5, A_STAT = 8'hE6, A_REL = 8'hE7, A_CMP = 8'hE8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq_o;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtt_timer_top #(.PSC_DIV(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_flag(input string tag, input int bitpos, input logic exp);
    logic [7:0] s;
    rd(A_STAT, s);
    chk(tag, {7'b0, s[bitpos]}, {7'b0, exp});
  endtask

  task automatic setup(input logic [7:0] rel, input logic [7:0] cmpv);
    wr(A_MODE, 8'h00);
    wr(A_STAT, 8'h00);
    wr(A_REL, rel);
    wr(A_CMP, cmpv);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(A_MODE, v); chk("R1 mode after reset", v, 8'h00);
    rd(A_STAT, v); chk("R1 status after reset", v, 8'h00);
    chk("R1 irq after reset", {7'b0, irq_o}, 8'h00);
    wr(A_CMP, 8'h01);
    idle(50);
    rd(A_STAT, v); chk("R1 R3 no count while stopped", v, 8'h00);
  endtask

  task automatic t_readback;
    logic [7:0] v;
    wr(A_REL, 8'hA5); rd(A_REL, v); chk("R10 R11 reload readback", v, 8'hA5);
    wr(A_CMP, 8'h3C); rd(A_CMP, v); chk("R10 R11 compare readback", v, 8'h3C);
    wr(A_MODE, 8'hFF); rd(A_MODE, v); chk("R2 R10 mode readback", v, 8'h4C);
    wr(A_MODE, 8'h00);
    wr(A_STAT, 8'hFF); rd(A_STAT, v); chk("R10 status upper bits", v & 8'hFC, 8'h00);
  endtask

  task automatic t_compare;
    setup(8'h10, 8'h13);
    wr(A_MODE, 8'hC0);          // load + run at E0
    idle(11); chk_flag("R4 R5 cmp not yet at E11", 1, 1'b0);
    idle(1);  chk_flag("R4 R5 cmp set at E12", 1, 1'b1);
    idle(8);  chk_flag("R5 cmp stays set", 1, 1'b1);
  endtask

  task automatic t_freeze;
    setup(8'h10, 8'h12);
    idle(1);                    // leave prescaler phase arbitrary before load
    wr(A_MODE, 8'hC0);          // E0
    idle(4);                    // after E4: counter 11h
    wr(A_MODE, 8'h00);          // stop at E5, prescaler phase 1
    idle(20);
    chk_flag("R3 frozen no match", 1, 1'b0);
    wr(A_MODE, 8'h40);          // resume at Ex
    idle(2); chk_flag("R3 resume phase held Ex+2", 1, 1'b0);
    idle(1); chk_flag("R3 R2 match at Ex+3", 1, 1'b1);
  endtask

  task automatic t_overflow;
    setup(8'hFE, 8'h00);
    wr(A_MODE, 8'hC0);          // E0
    idle(7); chk_flag("R6 ovf clear at E7", 0, 1'b0);
    idle(1); chk_flag("R6 ovf set at E8", 0, 1'b1);
    idle(7);                    // after E15
    wr(A_STAT, 8'h00);          // clear on E16, same edge as overflow
    chk_flag("R8 set wins over clear", 0, 1'b1);
    wr(A_STAT, 8'h00);          // E17
    chk_flag("R7 write zero clears ovf", 0, 1'b0);
    idle(6); chk_flag("R6 reload period E23", 0, 1'b0);
    idle(1); chk_flag("R6 reload period E24", 0, 1'b1);
  endtask

  task automatic t_reload_cmp;
    logic [7:0] v;
    setup(8'hFD, 8'hFE);
    wr(A_MODE, 8'hC0);          // E0
    idle(3); chk_flag("R5 cmp clear at E3", 1, 1'b0);
    idle(1); chk_flag("R5 cmp set at E4", 1, 1'b1);
    wr(A_STAT, 8'h01);          // E5: clear cmp, ovf written 1
    chk_flag("R7 cmp cleared by zero", 1, 1'b0);
    idle(6); chk_flag("R6 no ovf at E11", 0, 1'b0);
    idle(1); chk_flag("R6 ovf at E12", 0, 1'b1);
    idle(3); chk_flag("R6 cmp clear at E15", 1, 1'b0);
    idle(1); chk_flag("R6 counter reloaded, cmp at E16", 1, 1'b1);
    wr(A_STAT, 8'h03);          // E17: ones have no effect
    rd(A_STAT, v); chk("R7 writing ones keeps both", v, 8'h03);
    wr(A_STAT, 8'h01);          // E18: clear cmp only
    rd(A_STAT, v); chk("R7 selective clear", v, 8'h01);
  endtask

  task automatic t_irq;
    wr(A_MODE, 8'h00);
    chk("R9 irq masked", {7'b0, irq_o}, 8'h00);
    wr(A_MODE, 8'h04);
    chk("R9 ovf enable raises irq", {7'b0, irq_o}, 8'h01);
    wr(A_MODE, 8'h08);
    chk("R9 cmp enable no cmp flag", {7'b0, irq_o}, 8'h00);
    wr(A_STAT, 8'h00);
    wr(A_REL, 8'h20);
    wr(A_CMP, 8'h21);
    wr(A_MODE, 8'hCC);          // E0, both enables
    idle(3); chk("R9 irq low at E3", {7'b0, irq_o}, 8'h00);
    idle(1); chk("R9 irq on cmp at E4", {7'b0, irq_o}, 8'h01);
    wr(A_STAT, 8'h00);
    chk("R9 irq drops after clear", {7'b0, irq_o}, 8'h00);
    wr(A_MODE, 8'h00);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_readback();
    t_compare();
    t_freeze();
    t_overflow();
    t_reload_cmp();
    t_irq();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule